// File: doc/BRIEF.md
# Twisted-Ring Decade Counter with Seven-Segment Decode

This block counts pulses from 0 to 9 and drives one seven-segment digit with active-high segment outputs. The count is held in a five-bit twisted-ring (Johnson) register, which steps through ten states. Adjacent-bit decode turns each state into one of nine one-hot count terms. Each segment is worked out from the counts for which it must be dark. Count 8 lights every segment, so it needs no term at all.

The count clock is an ordinary sampled input. It is synchronised into the system clock domain, and its rising edge is detected there. A hold input suspends counting. A synchronous clear returns the digit to zero. A display enable blanks the segments without disturbing the count. Two more outputs serve further digits. The carry output rises exactly when the digit rolls from 9 to 0, so it can drive the count clock of the next digit. A copy of segment c is left ungated by the display enable. Every pin is a plain control or status level; there is no data stream and no handshake.

Top module: `jdec_seg_driver`

## Requirements
- R1: The digit counts 0,1,…,9 and then wraps to 0, advancing by one per qualified rising edge of `count_clk`. The ring state for count k is: 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000. Any state with more than one adjacent-bit transition is forced to 00000 on the next system clock.
- R2: Only a low-to-high change of the synchronised `count_clk` advances the count. A level held high for many clocks gives one step, and a falling change gives none.
- R3: While `count_hold` is high, a rising `count_clk` leaves the count unchanged.
- R4: While `clear` is high, the count becomes 0 at the next `clk` edge, even if a rising `count_clk` arrives at the same time.
- R5: `seg[6:0]` carries segments a..g, with a on bit 6 and g on bit 0, and 1 means lit. The patterns are 0:7E, 1:30, 2:6D, 3:79, 4:33, 5:5B, 6:5F, 7:70, 8:7F, 9:7B (hex).
- R6: Segment g is dark for counts 0, 1 and 7 only.
- R7: When `disp_on` is low, `seg` is 0000000. Counting continues, and the correct pattern returns as soon as `disp_on` goes high.
- R8: `carry_out` is high for counts 0 to 4 and low for counts 5 to 9, so it rises only on the 9-to-0 rollover.
- R9: `seg_c_raw` equals segment c of the current count whatever the level of `disp_on`.
- R10: A rising `count_clk` seen at the input changes the outputs after SYNC_STAGES+1 rising edges of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| clear | input | 1 | Synchronous active-high clear of the count and edge detector |
| count_clk | input | 1 | Count pulse input, sampled and edge-detected |
| count_hold | input | 1 | High blocks counting |
| disp_on | input | 1 | High lets the segments show the count; low blanks them |
| seg | output | 7 | Segments a..g on bits 6..0, active high |
| carry_out | output | 1 | High for counts 0–4; rising edge marks rollover |
| seg_c_raw | output | 1 | Segment c, not gated by disp_on |

## Verification
The bench walks the digit through two full revolutions and compares every glyph, the carry and the raw c segment with a table of its own. A wrong off-decode for one count would show up there as a single wrong pattern, and an inverted carry would rise at 5 instead of at rollover. It holds `count_clk` high for many clocks and then drops it. A level-sensitive or both-edge detector would count more than once. It also pulses under hold, under clear and with the display blanked. Each of these catches a design that still steps while held, lets an edge beat clear, blanks `seg_c_raw`, or freezes the count while dark.

// File: rtl/jdec_pkg.sv
package jdec_pkg;
  localparam int RING_W     = 5;
  localparam int NUM_COUNTS = 2 * RING_W;
  localparam int SEG_W      = 7;
  // bit positions of each segment in the segment bus
  localparam int SEG_A = 6;
  localparam int SEG_B = 5;
  localparam int SEG_C = 4;
  localparam int SEG_D = 3;
  localparam int SEG_E = 2;
  localparam int SEG_F = 1;
  localparam int SEG_G = 0;

  typedef logic [RING_W-1:0]     ring_t;
  typedef logic [SEG_W-1:0]      seg_t;
  typedef logic [NUM_COUNTS-1:0] terms_t;  // slot 8 is never driven high
endpackage

// File: rtl/jdec_edge.sv
module jdec_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clear,
  input  logic raw_in,
  input  logic hold,
  output logic step
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (clear) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
      prev_q <= synced;
    end
  end

  assign step = synced & ~prev_q & ~hold;
endmodule

// File: rtl/jdec_ring.sv
module jdec_ring
  import jdec_pkg::*;
(
  input  logic  clk,
  input  logic  clear,
  input  logic  step,
  output ring_t state
);
  ring_t                 state_q;
  ring_t                 shifted;
  logic  [RING_W-2:0]    edges;
  logic                  legal;

  // one-bit left shift with the inverted top bit fed back
  assign shifted[0] = ~state_q[RING_W-1];
  generate
    for (genvar i = 1; i < RING_W; i++) begin : g_shift
      assign shifted[i] = state_q[i-1];
    end
    for (genvar i = 0; i < RING_W - 1; i++) begin : g_edge
      assign edges[i] = state_q[i] ^ state_q[i+1];
    end
  endgenerate

  assign legal = ($countones(edges) <= 1);

  always_ff @(posedge clk) begin
    if (clear)       state_q <= '0;
    else if (!legal) state_q <= '0;
    else if (step)   state_q <= shifted;
  end

  assign state = state_q;
endmodule

// File: rtl/jdec_decode.sv
module jdec_decode
  import jdec_pkg::*;
(
  input  ring_t  state,
  input  logic   disp_on,
  output terms_t terms,
  output seg_t   seg,
  output logic   seg_c_raw
);
  seg_t lit;

  // adjacent-bit decode of the ring: nine terms, count 8 left out
  always_comb begin
    terms    = '0;
    terms[0] = ~state[RING_W-1] & ~state[0];
    terms[RING_W] = state[RING_W-1] & state[0];
    for (int k = 1; k < RING_W; k++)
      terms[k] = state[k-1] & ~state[k];
    for (int k = RING_W + 1; k < NUM_COUNTS; k++)
      if (k != 8)
        terms[k] = ~state[k-RING_W-1] & state[k-RING_W];
  end

  // each segment is lit unless a count that darkens it is active
  always_comb begin
    lit        = '1;
    lit[SEG_A] = ~(terms[1] | terms[4]);
    lit[SEG_B] = ~(terms[5] | terms[6]);
    lit[SEG_C] = ~terms[2];
    lit[SEG_D] = ~(terms[1] | terms[4] | terms[7]);
    lit[SEG_E] = ~(terms[1] | terms[3] | terms[4] | terms[5] | terms[7] | terms[9]);
    lit[SEG_F] = ~(terms[1] | terms[2] | terms[3] | terms[7]);
    lit[SEG_G] = ~(terms[0] | terms[1] | terms[7]);
  end

  assign seg       = disp_on ? lit : '0;
  assign seg_c_raw = lit[SEG_C];
endmodule

// File: rtl/jdec_seg_driver.sv
module jdec_seg_driver
  import jdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       clear,
  input  logic       count_clk,
  input  logic       count_hold,
  input  logic       disp_on,
  output logic [6:0] seg,
  output logic       carry_out,
  output logic       seg_c_raw
);
  logic   step;
  ring_t  state;
  terms_t terms;

  jdec_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .clear  (clear),
    .raw_in (count_clk),
    .hold   (count_hold),
    .step   (step)
  );

  jdec_ring u_ring (
    .clk   (clk),
    .clear (clear),
    .step  (step),
    .state (state)
  );

  jdec_decode u_dec (
    .state     (state),
    .disp_on   (disp_on),
    .terms     (terms),
    .seg       (seg),
    .seg_c_raw (seg_c_raw)
  );

  assign carry_out = ~state[RING_W-1];
endmodule

// File: rtl/jdec_seg_driver_chk.sv
module jdec_seg_driver_chk
  import jdec_pkg::*;
(
  input logic       clk,
  input logic       clear,
  input logic       count_hold,
  input logic       disp_on,
  input logic       step,
  input ring_t      state,
  input terms_t     terms,
  input logic [6:0] seg,
  input logic       carry_out,
  input logic       seg_c_raw
);
  assert_one_term_R1: assert property (@(posedge clk) disable iff (clear)
    $onehot0(terms));

  assert_no_step_when_held_R3: assert property (@(posedge clk) disable iff (clear)
    count_hold |=> $stable(state));

  assert_clear_zero_R4: assert property (@(posedge clk)
    clear |=> (state == '0));

  assert_blank_R7: assert property (@(posedge clk) disable iff (clear)
    !disp_on |-> (seg == '0));

  assert_carry_rollover_R8: assert property (@(posedge clk) disable iff (clear)
    $rose(carry_out) |-> (state == '0) && $past(step));

  assert_raw_c_R9: assert property (@(posedge clk) disable iff (clear)
    disp_on |-> (seg[SEG_C] == seg_c_raw));
endmodule

bind jdec_seg_driver jdec_seg_driver_chk u_chk (
  .clk        (clk),
  .clear      (clear),
  .count_hold (count_hold),
  .disp_on    (disp_on),
  .step       (step),
  .state      (state),
  .terms      (terms),
  .seg        (seg),
  .carry_out  (carry_out),
  .seg_c_raw  (seg_c_raw)
);

// File: tb/jdec_seg_driver_test.sv
module jdec_seg_driver_test;
  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic       count_clk = 1'b0;
  logic       count_hold = 1'b0;
  logic       disp_on = 1'b1;
  logic [6:0] seg;
  logic       carry_out;
  logic       seg_c_raw;

  int checks = 0;
  int fails  = 0;
  int exp_cnt = 0;

  always #10 clk = ~clk;

  jdec_seg_driver #(.SYNC_STAGES(2)) uut (
    .clk(clk), .clear(clear), .count_clk(count_clk), .count_hold(count_hold),
    .disp_on(disp_on), .seg(seg), .carry_out(carry_out), .seg_c_raw(seg_c_raw)
  );

  function automatic logic [6:0] glyph(int n);
    case (n)
      0: return 7'h7E; 1: return 7'h30; 2: return 7'h6D; 3: return 7'h79;
      4: return 7'h33; 5: return 7'h5B; 6: return 7'h5F; 7: return 7'h70;
      8: return 7'h7F; default: return 7'h7B;
    endcase
  endfunction

  task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, seg, disp_on ? glyph(exp_cnt) : 7'h00);
    chk({req, " carry R8"}, {6'd0, carry_out}, {6'd0, exp_cnt < 5});
    chk({req, " rawc R9"}, {6'd0, seg_c_raw}, {6'd0, glyph(exp_cnt)[4]});
  endtask

  task automatic pulse(int high_len);
    @(negedge clk) count_clk = 1'b1;
    repeat (high_len) @(negedge clk);
    count_clk = 1'b0;
    repeat (5) @(negedge clk);
    if (!count_hold && !clear) exp_cnt = (exp_cnt + 1) % 10;
  endtask

  task automatic test_reset;
    repeat (3) @(negedge clk);
    clear = 1'b0;
    @(negedge clk);
    exp_cnt = 0;
    check_all("R4 reset state");
  endtask

  task automatic test_cycle;
    for (int n = 0; n < 20; n++) begin
      pulse(4);
      check_all("R1 R5 sequence");
      if (exp_cnt == 0 || exp_cnt == 1 || exp_cnt == 7)
        chk("R6 g dark", {6'd0, seg[0]}, 7'd0);
    end
  endtask

  task automatic test_latency;
    // rising input before edge 1; outputs must move after edge 3
    @(negedge clk) count_clk = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 not yet", seg, glyph(exp_cnt));
    @(negedge clk);
    chk("R10 after S+1", seg, glyph((exp_cnt + 1) % 10));
    exp_cnt = (exp_cnt + 1) % 10;
    count_clk = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic test_level;
    pulse(40);
    check_all("R2 long high one step");
  endtask

  task automatic test_hold;
    count_hold = 1'b1;
    pulse(4);
    pulse(4);
    check_all("R3 held");
    count_hold = 1'b0;
    pulse(4);
    check_all("R3 released");
  endtask

  task automatic test_blank;
    disp_on = 1'b0;
    @(negedge clk);
    check_all("R7 blanked");
    pulse(4);
    pulse(4);
    check_all("R7 counting while dark");
    disp_on = 1'b1;
    @(negedge clk);
    check_all("R7 restored");
  endtask

  task automatic test_clear;
    while (exp_cnt != 9) pulse(4);
    check_all("R8 at nine");
    @(negedge clk) begin clear = 1'b1; count_clk = 1'b1; end
    repeat (4) @(negedge clk);
    exp_cnt = 0;
    check_all("R4 clear beats edge");
    count_clk = 1'b0;
    @(negedge clk) clear = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R4 after clear");
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset;
    test_cycle;
    test_latency;
    test_level;
    test_hold;
    test_blank;
    test_clear;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule